// File: doc/BRIEF.md
# Ping-Pong Register Cache for a Three-Pass Butterfly Engine

This block sits between a single-port data memory and an 8-word butterfly computation engine. It holds two 8-word register banks that trade roles at every swap. The bank facing memory first writes the results of the group it last served back to memory, one word per cycle, and then loads the next group, again one word per cycle. Meanwhile the bank facing the engine presents all eight words in parallel and captures the engine's parallel output at the end of each of three passes. The second pass is flagged by a select output so that the engine can reconfigure its routing.

A transform of N groups is started with one pulse. An external sequencer then issues swap pulses, and the block accepts a swap only once both sides have finished their share of the current window. The whole memory schedule (addresses, read/write direction and word order) is produced inside the block. The three passes take three cycles and fit inside the memory window, so the memory never waits for the engine. A busy flag covers the run, and a done pulse marks the end of the last write-back.

Top module: `fft_pingpong_cache`

## Requirements
- R1: After reset, busy_o, done_o, swap_rdy_o, mem_en_o, mem_we_o, ce_valid_o and ce_sel_o are all low.
- R2: A start pulse with ngrp_i of 1 or more, taken while idle, issues 8 reads of group 0 in the following cycles, one per cycle. The word offsets run 0 to 7, and mem_addr_o equals group*8 + offset, so bits [2:0] hold the offset. The block takes read data on mem_rdata_i one cycle after each request.
- R3: A start pulse is ignored while a run is in progress, and it is also ignored when ngrp_i is 0.
- R4: The memory port performs at most one access per cycle, and mem_we_o is never high without mem_en_o.
- R5: swap_rdy_o is high only when the memory-side bank has finished its write-back, its reads and the capture of the last read word, and the engine-side bank has finished pass 3 or holds no group. A swap_i pulse while swap_rdy_o is low changes nothing.
- R6: After an accepted swap that hands a loaded group to the engine, ce_valid_o is high for exactly 3 consecutive cycles with ce_pass_o = 0, 1, 2. ce_data_o carries the loaded group in pass 0, and in each later pass it carries the result captured at the end of the previous pass.
- R7: ce_sel_o is 1 in the cycle of pass index 1 only, and 0 in the cycles of pass indices 0 and 2.
- R8: In window w (counted from 0 at start and incremented by each swap), the block first writes back results for group w-2 if w ≥ 2, words 0 to 7 in order, and then reads group w if w < N. Groups beyond N-1 are never written.
- R9: Words are 36 bits, with the real part in [35:18] and the imaginary part in [17:0], both two's complement. Word i of a group sits in ce_data_o/ce_res_i bits [36*i+35:36*i]. The block passes words through without altering them.
- R10: busy_o is high from the first read cycle through the last write cycle. done_o is a one-cycle pulse in the cycle after the last write, and busy_o is low in that cycle.
- R11: With swap_i held high, a window that has both write-back and reads lasts exactly 18 cycles, and a window that has reads only lasts 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a new run |
| ngrp_i | input | GRP_W | Number of 8-word groups in the run |
| swap_i | input | 1 | Request to exchange bank roles |
| swap_rdy_o | output | 1 | A swap would be accepted this cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the final write-back |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | GRP_W+3 | Word address, group*8 + offset |
| mem_wdata_o | output | 36 | Word being written back |
| mem_rdata_i | input | 36 | Read word, valid one cycle after the request |
| ce_data_o | output | 288 | Eight words from the engine-side bank |
| ce_res_i | input | 288 | Eight result words from the engine |
| ce_valid_o | output | 1 | Pass active this cycle |
| ce_pass_o | output | 2 | Pass index 0..2 |
| ce_sel_o | output | 1 | Engine routing select, high in the middle pass |

## Verification
The risky overlap is a pass capture into the engine-side bank in the same cycle as a returning read word lands in the memory-side bank. Holding swap_i high makes the first passes of a group line up with the early read captures of the next group, so both banks are written on the same clock edge. The bench judges this with a per-cycle reference model of every memory command, every write-back word and every engine input. After each run it also compares memory contents word by word against the three-stage butterfly result it computes itself. Runs with sparse swap pulses move the same collisions to other cycles and also exercise swaps that must be refused.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // memory-side phase of one window
    typedef enum logic [1:0] {
        MP_IDLE  = 2'd0,
        MP_WR    = 2'd1,
        MP_RD    = 2'd2,
        MP_DRAIN = 2'd3
    } mphase_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/fpc_bank.sv
module fpc_bank #(
    parameter int DW    = 36,
    parameter int NWORD = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_we,
    input  logic [$clog2(NWORD)-1:0] ser_idx,
    input  logic [DW-1:0]            ser_wdata,
    input  logic                     par_we,
    input  logic [NWORD*DW-1:0]      par_wdata,
    input  logic [$clog2(NWORD)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [NWORD*DW-1:0]      par_q
);
    localparam int IW = $clog2(NWORD);

    typedef struct packed {
        logic [NWORD*DW-1:0] words;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (par_we) begin
            st_d.words = par_wdata;
        end
        if (ser_we) begin
            st_d.words[int'(ser_idx)*DW +: DW] = ser_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [IW-1:0] rd_sel;
    assign rd_sel  = rd_idx;
    assign rd_data = st_q.words[int'(rd_sel)*DW +: DW];
    assign par_q   = st_q.words;

endmodule

// File: rtl/fpc_mem_seq.sv
module fpc_mem_seq
    import fpc_pkg::*;
#(
    parameter int NWORD = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kick,
    input  logic                     kick_wr,
    input  logic                     kick_rd,
    input  logic                     cont_rd,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [$clog2(NWORD)-1:0] word,
    output logic                     cap_vld,
    output logic [$clog2(NWORD)-1:0] cap_idx,
    output logic                     idle
);
    localparam int IW = $clog2(NWORD);
    localparam logic [IW-1:0] LAST_W = IW'(NWORD - 1);

    typedef struct packed {
        mphase_e       phase;
        logic [IW-1:0] word;
        logic          cap_vld;
        logic [IW-1:0] cap_idx;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cap_vld = (st_q.phase == MP_RD);
        st_d.cap_idx = st_q.word;
        unique case (st_q.phase)
            MP_WR: begin
                if (st_q.word == LAST_W) begin
                    st_d.word  = '0;
                    st_d.phase = cont_rd ? MP_RD : MP_IDLE;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end
            MP_RD: begin
                if (st_q.word == LAST_W) begin
                    st_d.word  = '0;
                    st_d.phase = MP_DRAIN;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end
            MP_DRAIN: st_d.phase = MP_IDLE;
            default:  st_d.phase = MP_IDLE;
        endcase
        if (kick) begin
            st_d.word  = '0;
            st_d.phase = kick_wr ? MP_WR : (kick_rd ? MP_RD : MP_IDLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: MP_IDLE, word: '0, cap_vld: 1'b0, cap_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_en  = (st_q.phase == MP_WR) || (st_q.phase == MP_RD);
    assign mem_we  = (st_q.phase == MP_WR);
    assign word    = st_q.word;
    assign cap_vld = st_q.cap_vld;
    assign cap_idx = st_q.cap_idx;
    assign idle    = (st_q.phase == MP_IDLE);

endmodule

// File: rtl/fpc_pass_ctl.sv
module fpc_pass_ctl #(
    parameter int NPASS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kick,
    output logic                     valid,
    output logic [$clog2(NPASS)-1:0] pass,
    output logic                     sel,
    output logic                     done
);
    localparam int PW = $clog2(NPASS);
    localparam logic [PW-1:0] LAST_P = PW'(NPASS - 1);
    localparam logic [PW-1:0] MID_P  = PW'(NPASS / 2);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] pass;
    } pass_st_t;

    pass_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.pass == LAST_P) begin
                st_d.active = 1'b0;
                st_d.pass   = '0;
            end else begin
                st_d.pass = st_q.pass + 1'b1;
            end
        end
        if (kick) begin
            st_d.active = 1'b1;
            st_d.pass   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.active;
    assign pass  = st_q.pass;
    assign sel   = st_q.active && (st_q.pass == MID_P);
    assign done  = !st_q.active;

endmodule

// File: rtl/fft_pingpong_cache.sv
module fft_pingpong_cache
    import fpc_pkg::*;
#(
    parameter int PART_W = 18,
    parameter int NWORD  = 8,
    parameter int NPASS  = 3,
    parameter int GRP_W  = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [GRP_W-1:0]                      ngrp_i,
    input  logic                                  swap_i,
    output logic                                  swap_rdy_o,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic                                  mem_en_o,
    output logic                                  mem_we_o,
    output logic [GRP_W+$clog2(NWORD)-1:0]        mem_addr_o,
    output logic [2*PART_W-1:0]                   mem_wdata_o,
    input  logic [2*PART_W-1:0]                   mem_rdata_i,
    output logic [NWORD*2*PART_W-1:0]             ce_data_o,
    input  logic [NWORD*2*PART_W-1:0]             ce_res_i,
    output logic                                  ce_valid_o,
    output logic [$clog2(NPASS)-1:0]              ce_pass_o,
    output logic                                  ce_sel_o
);
    localparam int DW    = 2 * PART_W;
    localparam int IW    = $clog2(NWORD);
    localparam int AW    = GRP_W + IW;
    localparam int WIN_W = GRP_W + 1;

    typedef struct packed {
        logic             run;
        logic [GRP_W-1:0] ngrp;
        logic [WIN_W-1:0] win;
        logic             sel;   // index of the memory-side bank
        logic             busy;
        logic             done;
    } top_st_t;

    top_st_t st_d, st_q;

    // sub-block wiring
    logic          seq_kick, seq_kick_wr, seq_kick_rd, seq_cont_rd;
    logic          seq_en, seq_we, seq_cap_vld, seq_idle;
    logic [IW-1:0] seq_word, seq_cap_idx;
    logic          pc_kick, pc_valid, pc_sel, pc_done;
    logic [$clog2(NPASS)-1:0] pc_pass;

    // window decode
    logic [WIN_W-1:0] ngrp_ext, win_new, win_m2, grp_full;
    logic             final_win, cur_rd, swap_rdy, start_ok, swap_ok, fin;

    always_comb begin
        ngrp_ext    = WIN_W'(st_q.ngrp);
        win_new     = st_q.win + 1'b1;
        win_m2      = st_q.win - WIN_W'(2);
        final_win   = st_q.run && (st_q.win == ngrp_ext + 1'b1);
        cur_rd      = (st_q.win < ngrp_ext);
        swap_rdy    = st_q.run && !final_win && seq_idle && pc_done;
        start_ok    = start_i && !st_q.run && (ngrp_i != '0);
        swap_ok     = swap_i && swap_rdy;
        fin         = final_win && seq_we && (seq_word == IW'(NWORD - 1));

        seq_kick    = start_ok || swap_ok;
        seq_kick_wr = swap_ok && (win_new >= WIN_W'(2));
        seq_kick_rd = start_ok || (swap_ok && (win_new < ngrp_ext));
        seq_cont_rd = cur_rd;
        pc_kick     = swap_ok && (win_new <= ngrp_ext);
        grp_full    = seq_we ? win_m2 : st_q.win;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_ok) begin
            st_d.run  = 1'b1;
            st_d.ngrp = ngrp_i;
            st_d.win  = '0;
            st_d.sel  = 1'b0;
            st_d.busy = 1'b1;
        end else if (swap_ok) begin
            st_d.win = win_new;
            st_d.sel = !st_q.sel;
        end else if (fin) begin
            st_d.run  = 1'b0;
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fpc_mem_seq #(.NWORD(NWORD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (seq_kick),
        .kick_wr (seq_kick_wr),
        .kick_rd (seq_kick_rd),
        .cont_rd (seq_cont_rd),
        .mem_en  (seq_en),
        .mem_we  (seq_we),
        .word    (seq_word),
        .cap_vld (seq_cap_vld),
        .cap_idx (seq_cap_idx),
        .idle    (seq_idle)
    );

    fpc_pass_ctl #(.NPASS(NPASS)) u_pass (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (pc_kick),
        .valid (pc_valid),
        .pass  (pc_pass),
        .sel   (pc_sel),
        .done  (pc_done)
    );

    logic [DW-1:0]       bank_ser [NUM_BANKS];
    logic [NWORD*DW-1:0] bank_par [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_mem;
        assign is_mem = (st_q.sel == 1'(b));
        fpc_bank #(.DW(DW), .NWORD(NWORD)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ser_we    (is_mem && seq_cap_vld),
            .ser_idx   (seq_cap_idx),
            .ser_wdata (mem_rdata_i),
            .par_we    (!is_mem && pc_valid),
            .par_wdata (ce_res_i),
            .rd_idx    (seq_word),
            .rd_data   (bank_ser[b]),
            .par_q     (bank_par[b])
        );
    end

    assign mem_en_o    = seq_en;
    assign mem_we_o    = seq_we;
    assign mem_addr_o  = AW'({grp_full, seq_word});
    assign mem_wdata_o = bank_ser[st_q.sel];
    assign ce_data_o   = bank_par[!st_q.sel];
    assign ce_valid_o  = pc_valid;
    assign ce_pass_o   = pc_pass;
    assign ce_sel_o    = pc_sel;
    assign swap_rdy_o  = swap_rdy;
    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_en,
    input logic          mem_we,
    input logic          ce_valid,
    input logic [PW-1:0] ce_pass,
    input logic          ce_sel,
    input logic          swap_rdy
);
    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en); // R4
    AST_MEM_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> busy); // R10
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R10
    AST_NO_RDY_MID_PASS: assert property (@(posedge clk) disable iff (!rst_n) ce_valid |-> !swap_rdy); // R5
    AST_NO_RDY_MEM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> !swap_rdy); // R5
    AST_PASS_0_TO_1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && ce_pass == PW'(0)) |=> (ce_valid && ce_pass == PW'(1))); // R6
    AST_PASS_1_TO_2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && ce_pass == PW'(1)) |=> (ce_valid && ce_pass == PW'(2))); // R6
    AST_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && ce_pass == PW'(2)) |=> !ce_valid); // R6
    AST_SEL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ce_sel |-> (ce_valid && ce_pass == PW'(1))); // R7
endmodule

bind fft_pingpong_cache fpc_checker #(.PW($clog2(NPASS))) u_fpc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_o),
    .done     (done_o),
    .mem_en   (mem_en_o),
    .mem_we   (mem_we_o),
    .ce_valid (ce_valid_o),
    .ce_pass  (ce_pass_o),
    .ce_sel   (ce_sel_o),
    .swap_rdy (swap_rdy_o)
);

// File: tb/fft_pingpong_cache_tb_top.sv
`timescale 1ns/1ps
module fft_pingpong_cache_tb_top;
    localparam int DW = 36;
    localparam int NW = 8;
    localparam int GW = 6;
    localparam int AW = GW + 3;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [GW-1:0] ngrp_i = '0;
    logic swap_i = 1'b0;
    logic swap_rdy_o, busy_o, done_o, mem_en_o, mem_we_o, ce_valid_o, ce_sel_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i;
    logic [NW*DW-1:0] ce_data_o, ce_res_i;
    logic [1:0] ce_pass_o;

    always #4 clk = ~clk;

    fft_pingpong_cache dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ngrp_i(ngrp_i),
        .swap_i(swap_i), .swap_rdy_o(swap_rdy_o), .busy_o(busy_o), .done_o(done_o),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .ce_data_o(ce_data_o), .ce_res_i(ce_res_i), .ce_valid_o(ce_valid_o),
        .ce_pass_o(ce_pass_o), .ce_sel_o(ce_sel_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [NW*DW-1:0] act,
                       input logic [NW*DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stimulus word: real in [35:18], imaginary in [17:0]
    function automatic logic [DW-1:0] init_word(input int a);
        logic [17:0] re, im;
        re = 18'(a * 37 + 5);
        im = 18'(-(a * 11 + 3));
        return {re, im};
    endfunction

    // engine model: radix-2 butterflies across index bit p
    function automatic logic [NW*DW-1:0] bfly(input logic [NW*DW-1:0] d, input int p);
        logic [NW*DW-1:0] o;
        for (int i = 0; i < NW; i++) begin
            int j = i ^ (1 << p);
            logic [17:0] ar, ai, br, bi;
            ar = d[i*DW+18 +: 18]; ai = d[i*DW +: 18];
            br = d[j*DW+18 +: 18]; bi = d[j*DW +: 18];
            if (((i >> p) & 1) == 0) o[i*DW +: DW] = {18'(ar + br), 18'(ai + bi)};
            else                     o[i*DW +: DW] = {18'(br - ar), 18'(bi - ai)};
        end
        return o;
    endfunction

    function automatic logic [NW*DW-1:0] grp_in(input int g);
        logic [NW*DW-1:0] v;
        for (int i = 0; i < NW; i++) v[i*DW +: DW] = init_word(g * NW + i);
        return v;
    endfunction

    function automatic logic [NW*DW-1:0] grp_stage(input int g, input int np);
        logic [NW*DW-1:0] v;
        v = grp_in(g);
        for (int p = 0; p < np; p++) v = bfly(v, p);
        return v;
    endfunction

    always_comb ce_res_i = bfly(ce_data_o, int'(ce_pass_o));

    // single-port memory model, one-cycle read latency
    logic [DW-1:0] tb_mem [MEMSZ];
    logic init_req = 1'b0;
    always @(posedge clk) begin
        if (init_req) begin
            for (int a = 0; a < MEMSZ; a++) tb_mem[a] <= init_word(a);
        end else if (mem_en_o && mem_we_o) begin
            tb_mem[mem_addr_o] <= mem_wdata_o;
        end else if (mem_en_o) begin
            mem_rdata_i <= tb_mem[mem_addr_o];
        end
    end

    // behavioural reference: window number and cycle within window
    bit m_run = 0, m_busy = 0, m_done = 0;
    int m_n = 0, m_win = 0, m_k = 0;

    function automatic bit m_rdy();
        bit wr, rd, comp;
        int memend;
        wr = m_win >= 2; rd = m_win < m_n;
        comp = (m_win >= 1) && (m_win <= m_n);
        memend = rd ? ((wr ? 8 : 0) + 9) : (wr ? 8 : 0);
        return m_run && (m_win != m_n + 1) && (m_k >= memend) && !(comp && m_k < 3);
    endfunction

    always @(posedge clk) begin
        cyc_cnt++;
        if (!rst_n) begin
            m_run = 0; m_busy = 0; m_done = 0;
        end else begin
            bit rdy;
            rdy = m_rdy();
            m_done = 0;
            if (!m_run) begin
                if (start_i && ngrp_i != 0) begin
                    m_run = 1; m_busy = 1; m_n = int'(ngrp_i); m_win = 0; m_k = 0;
                end
            end else if (rdy && swap_i) begin
                m_win++; m_k = 0;
            end else if (m_win == m_n + 1 && m_k == 7) begin
                m_run = 0; m_busy = 0; m_done = 1;
            end else begin
                m_k++;
            end
        end
    end

    int p0_cyc[$];

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit wr, rd, e_en, e_we, e_val;
            int k0, e_addr, e_grp;
            wr = m_run && m_win >= 2; rd = m_run && m_win < m_n; k0 = wr ? 8 : 0;
            e_en = 0; e_we = 0; e_addr = 0; e_grp = 0;
            if (wr && m_k < 8) begin
                e_en = 1; e_we = 1; e_grp = m_win - 2; e_addr = e_grp * 8 + m_k;
            end else if (rd && m_k >= k0 && m_k < k0 + 8) begin
                e_en = 1; e_addr = m_win * 8 + m_k - k0;
            end
            e_val = m_run && m_win >= 1 && m_win <= m_n && m_k < 3;
            chk(busy_o == m_busy, "R10 busy", busy_o, m_busy);
            chk(done_o == m_done, "R10 done", done_o, m_done);
            chk(swap_rdy_o == m_rdy(), "R5 swap_rdy", swap_rdy_o, m_rdy());
            chk(mem_en_o == e_en && mem_we_o == e_we, "R8 R2 mem cmd",
                {mem_en_o, mem_we_o}, {e_en, e_we});
            if (e_en) chk(mem_addr_o == AW'(e_addr), "R2 R8 address", mem_addr_o, e_addr);
            if (e_we) chk(mem_wdata_o == grp_stage(e_grp, 3)[m_k*DW +: DW], "R8 R9 write data",
                          mem_wdata_o, grp_stage(e_grp, 3)[m_k*DW +: DW]);
            chk(ce_valid_o == e_val, "R6 ce_valid", ce_valid_o, e_val);
            chk(ce_sel_o == (e_val && m_k == 1), "R7 ce_sel", ce_sel_o, (e_val && m_k == 1));
            if (e_val) begin
                chk(ce_pass_o == 2'(m_k), "R6 pass index", ce_pass_o, m_k);
                chk(ce_data_o == grp_stage(m_win - 1, m_k), "R6 R9 engine data",
                    ce_data_o, grp_stage(m_win - 1, m_k));
                if (m_k == 0) p0_cyc.push_back(cyc_cnt);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic load_mem();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    // mode 0: swap held high; mode 1: sparse swap pulses
    task automatic run(input int n, input int mode);
        int c;
        load_mem();
        p0_cyc.delete();
        @(negedge clk); start_i = 1'b1; ngrp_i = GW'(n);
        @(negedge clk); start_i = 1'b0;
        c = 0;
        while (!done_o && c < 4000) begin
            swap_i  = (mode == 0) ? 1'b1 : (c % 7 == 3);
            start_i = (c == 20);        // R3: ignored while busy
            ngrp_i  = GW'(9);
            @(negedge clk); c++;
        end
        swap_i = 1'b0; start_i = 1'b0;
        chk(done_o, "R10 run finished", done_o, 1);
        for (int g = 0; g < n; g++)
            for (int i = 0; i < NW; i++)
                chk(tb_mem[g*NW+i] == grp_stage(g, 3)[i*DW +: DW], "R8 R9 memory result",
                    tb_mem[g*NW+i], grp_stage(g, 3)[i*DW +: DW]);
        chk(tb_mem[n*NW] == init_word(n*NW), "R8 group beyond N untouched",
            tb_mem[n*NW], init_word(n*NW));
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, swap_rdy_o, mem_en_o, mem_we_o, ce_valid_o, ce_sel_o} == 7'b0,
            "R1 reset outputs", {busy_o, done_o, swap_rdy_o, mem_en_o, mem_we_o, ce_valid_o, ce_sel_o}, 0);

        // R3: start with zero groups
        load_mem();
        @(negedge clk); start_i = 1'b1; ngrp_i = '0;
        @(negedge clk); start_i = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(!busy_o && !mem_en_o, "R3 zero-group start ignored", {busy_o, mem_en_o}, 0);
        end

        run(1, 0);
        run(3, 0);
        // R11 window lengths with swap held high
        if (p0_cyc.size() == 3) begin
            chk(p0_cyc[1] - p0_cyc[0] == 10, "R11 read-only window", p0_cyc[1] - p0_cyc[0], 10);
            chk(p0_cyc[2] - p0_cyc[1] == 18, "R11 full window", p0_cyc[2] - p0_cyc[1], 18);
        end else begin
            chk(0, "R11 pass-0 count", p0_cyc.size(), 3);
        end
        run(2, 1);
        run(5, 0);
        run(4, 1);
        summary();
        $finish;
    end

endmodule